// File: doc/BRIEF.md
# Three-Bus Datapath Register Bank

This block is the register bank of a 16-bit microcoded processor datapath. Two combinational read ports (the A and B buses) feed the ALU. A write port (the C bus) takes the ALU result back into the bank. Each port is steered by its own 5-bit register select, and the C port also needs a write enable. The bank holds four read-only constant registers, a set of read/write registers, a 12-bit memory address register loaded from the B bus, and a memory data register. The memory data register sits on a bidirectional memory data bus.

A microinstruction lasts three clock cycles. The sequencer marks the second and third with the phase strobes `ph_t2` and `ph_t3`. The memory address register captures the B bus at the end of the second phase. The C-bus registers capture at the end of the third phase. As a result, one microinstruction can copy a register to the address register and also update that register, and the address register receives the old value. A memory access uses two microinstructions. The first sets up the address and, for a write, the data. The second raises the read or write strobe.

Top module: `dpr_regfile`

## Requirements
- R1: After reset, every read/write register (select codes 4 and 6 to 15), the memory data register (select code 5) and the memory address register hold zero, and `mem_addr` is zero.
- R2: `a_bus` and `b_bus` each present, combinationally, the register whose code is on `sel_a` or `sel_b`. Both may select the same register. Select codes 16 to 31 address no register and read as zero.
- R3: The select codes 0, 1, 2 and 3 read as the constants 0x0000, 0x0001, 0xFFFF and 0x8000. A C-bus write to those codes leaves them unchanged.
- R4: The register named by `sel_c` loads `c_bus` at a rising clock edge only when `ph_t3` and `c_we` are both high. With `c_we` low, no register changes. A C-bus write to codes 16 to 31 changes no register.
- R5: The memory address register loads `b_bus[11:0]` at a rising edge where `ph_t2` and `mar_ld` are both high, holds its value at every other edge, and drives `mem_addr`.
- R6: In a microinstruction that both reads a register on B into the address register and writes that register through C, the address register receives the old value. Until the `ph_t3` edge, the A bus still shows the old value.
- R7: While `mem_rd` is high, the memory data register loads `mem_data` at every rising edge. A C-bus write to code 5 in the same edge is dropped.
- R8: When `mem_wr` is high and `mem_rd` is low, the block drives `mem_data` with the memory data register. At all other times it releases the bus, so an external driver sets its value.
- R9: One register may be selected on A, B and C in the same microinstruction. Both read buses show the old value until the `ph_t3` edge, and the new value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_t2 | input | 1 | Second-phase strobe of a microinstruction |
| ph_t3 | input | 1 | Third-phase strobe of a microinstruction |
| sel_a | input | 5 | Register select for the A bus |
| sel_b | input | 5 | Register select for the B bus |
| sel_c | input | 5 | Register select for the C-bus write |
| c_we | input | 1 | C-bus write enable |
| c_bus | input | 16 | Write data (ALU result) |
| mar_ld | input | 1 | Load the memory address register from B |
| mem_rd | input | 1 | Memory read strobe; also sets the bus direction |
| mem_wr | input | 1 | Memory write strobe |
| a_bus | output | 16 | A read bus |
| b_bus | output | 16 | B read bus |
| mem_addr | output | 12 | Memory address bus |
| mem_data | inout | 16 | Bidirectional memory data bus |

## Verification
Two pairs of events can land in the same microinstruction. The first is an address-register load from B together with a C-bus update of the same register. The bench provokes it with an increment of register 6 while that register is also copied to the address register. It judges the result by sampling `mem_addr` and the A bus between the second-phase and third-phase edges, and again after the third-phase edge. The second is a memory read together with a C-bus write to the data register. The bench drives the data bus and the C bus with different patterns and reads the register back on A, where only the memory pattern may appear.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   // Kind of value held by a constant slot of the bank
   typedef enum logic [1:0] {
      CK_ZERO    = 2'd0,
      CK_ONE     = 2'd1,
      CK_ALLONES = 2'd2,
      CK_TOPBIT  = 2'd3
   } const_kind_e;

   function automatic const_kind_e const_kind(input int idx);
      return const_kind_e'(idx[1:0]);
   endfunction
endpackage

// File: rtl/dpr_gp_reg.sv
module dpr_gp_reg #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/dpr_mdr.sv
module dpr_mdr #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mem_rd,
   input  logic [DW-1:0] mem_in,
   input  logic          c_ld,
   input  logic [DW-1:0] c_in,
   output logic [DW-1:0] q
);
   // memory side has priority: a read strobe overrides any C-bus load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (mem_rd) q <= mem_in;
      else if (c_ld)   q <= c_in;
   end
endmodule

// File: rtl/dpr_mar.sv
module dpr_mar #(
   parameter int DW = 16,
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] b_in,
   output logic [AW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= b_in[AW-1:0];
   end
endmodule

// File: rtl/dpr_read_port.sv
module dpr_read_port #(
   parameter int DW       = 16,
   parameter int SEL_W    = 5,
   parameter int NUM_REGS = 16
) (
   input  logic [SEL_W-1:0]               sel,
   input  logic [NUM_REGS-1:0][DW-1:0]    regs,
   output logic [DW-1:0]                  bus
);
   // AND-OR selection: an unmatched code leaves the bus at zero
   always_comb begin
      bus = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (sel == SEL_W'(i)) bus = bus | regs[i];
      end
   end
endmodule

// File: rtl/dpr_regfile.sv
module dpr_regfile
   import dpr_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 12,
   parameter int SEL_W     = 5,
   parameter int NUM_REGS  = 16,
   parameter int NUM_CONST = 4,
   parameter int MDR_IDX   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ph_t2,
   input  logic             ph_t3,
   input  logic [SEL_W-1:0] sel_a,
   input  logic [SEL_W-1:0] sel_b,
   input  logic [SEL_W-1:0] sel_c,
   input  logic             c_we,
   input  logic [DW-1:0]    c_bus,
   input  logic             mar_ld,
   input  logic             mem_rd,
   input  logic             mem_wr,
   output logic [DW-1:0]    a_bus,
   output logic [DW-1:0]    b_bus,
   output logic [AW-1:0]    mem_addr,
   inout  wire  [DW-1:0]    mem_data
);
   localparam int MAX_CODES = 1 << SEL_W;

   // elaboration-time parameter checks
   if (AW > DW) begin : g_bad_aw
      $error("address width exceeds data width");
   end
   if (NUM_REGS > MAX_CODES) begin : g_bad_nregs
      $error("more registers than select codes");
   end
   if (NUM_CONST > 4 || NUM_CONST < 2) begin : g_bad_const
      $error("constant slot count must be 2 to 4");
   end
   if (MDR_IDX < NUM_CONST || MDR_IDX >= NUM_REGS) begin : g_bad_mdr
      $error("memory data register index out of range");
   end

   function automatic logic [DW-1:0] const_word(input int idx);
      case (const_kind(idx))
         CK_ZERO:    return '0;
         CK_ONE:     return DW'(1);
         CK_ALLONES: return '1;
         default:    return {1'b1, {(DW-1){1'b0}}};
      endcase
   endfunction

   logic [NUM_REGS-1:0][DW-1:0] reg_q;
   logic [NUM_REGS-1:0]         c_hit;
   logic                        c_load;
   logic                        drive_mem;

   assign c_load = ph_t3 && c_we;

   always_comb begin
      for (int i = 0; i < NUM_REGS; i++) begin
         c_hit[i] = c_load && (sel_c == SEL_W'(i));
      end
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      if (i < NUM_CONST) begin : g_const
         assign reg_q[i] = const_word(i);
      end else if (i == MDR_IDX) begin : g_mdr
         dpr_mdr #(.DW(DW)) u_mdr (
            .clk    (clk),
            .rst_n  (rst_n),
            .mem_rd (mem_rd),
            .mem_in (mem_data),
            .c_ld   (c_hit[i]),
            .c_in   (c_bus),
            .q      (reg_q[i])
         );
      end else begin : g_rw
         dpr_gp_reg #(.DW(DW)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (c_hit[i]),
            .d     (c_bus),
            .q     (reg_q[i])
         );
      end
   end

   dpr_read_port #(.DW(DW), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)) u_port_a (
      .sel  (sel_a),
      .regs (reg_q),
      .bus  (a_bus)
   );

   dpr_read_port #(.DW(DW), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)) u_port_b (
      .sel  (sel_b),
      .regs (reg_q),
      .bus  (b_bus)
   );

   dpr_mar #(.DW(DW), .AW(AW)) u_mar (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ph_t2 && mar_ld),
      .b_in  (b_bus),
      .q     (mem_addr)
   );

   assign drive_mem = mem_wr && !mem_rd;
   assign mem_data  = drive_mem ? reg_q[MDR_IDX] : {DW{1'bz}};
endmodule

// File: rtl/dpr_regfile_chk.sv
module dpr_regfile_chk #(
   parameter int DW        = 16,
   parameter int AW        = 12,
   parameter int SEL_W     = 5,
   parameter int NUM_REGS  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ph_t2,
   input logic [SEL_W-1:0] sel_a,
   input logic [SEL_W-1:0] sel_b,
   input logic             mar_ld,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic [DW-1:0]    a_bus,
   input logic [DW-1:0]    b_bus,
   input logic [AW-1:0]    mem_addr,
   input logic [DW-1:0]    mem_data
);
   // R3
   const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a == SEL_W'(1)) |-> (a_bus == DW'(1)));

   // R3
   const_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_b == SEL_W'(2)) |-> (b_bus == '1));

   // R2
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_a) >= NUM_REGS) |-> (a_bus == '0));

   // R5
   mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_t2 && mar_ld) |=> (mem_addr == $past(b_bus[AW-1:0])));

   // R5
   mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph_t2 && mar_ld) |=> $stable(mem_addr));

   // R8
   wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_rd) |-> !$isunknown(mem_data));

   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd));
endmodule

bind dpr_regfile dpr_regfile_chk #(
   .DW(DW), .AW(AW), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ph_t2(ph_t2), .sel_a(sel_a), .sel_b(sel_b),
   .mar_ld(mar_ld), .mem_rd(mem_rd), .mem_wr(mem_wr), .a_bus(a_bus),
   .b_bus(b_bus), .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/dpr_regfile_bench.sv
`timescale 1ns/1ps
module dpr_regfile_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ph_t2 = 1'b0, ph_t3 = 1'b0;
   logic [4:0]  sel_a = '0, sel_b = '0, sel_c = '0;
   logic        c_we = 1'b0, mar_ld = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
   logic [15:0] c_bus = '0;
   logic [15:0] a_bus, b_bus;
   logic [11:0] mem_addr;
   wire  [15:0] mem_data;
   logic        tb_drv = 1'b0;
   logic [15:0] tb_val = '0;

   int total = 0;
   int bad = 0;
   logic [15:0] mdl [16];
   logic [15:0] mid_a, mid_mem;
   logic [11:0] mid_addr;

   assign mem_data = tb_drv ? tb_val : 16'hzzzz;

   always #5 clk = ~clk;

   dpr_regfile u_dpr_regfile (
      .clk(clk), .rst_n(rst_n), .ph_t2(ph_t2), .ph_t3(ph_t3),
      .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .c_we(c_we),
      .c_bus(c_bus), .mar_ld(mar_ld), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .a_bus(a_bus), .b_bus(b_bus), .mem_addr(mem_addr), .mem_data(mem_data)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one microinstruction: three cycles, strobes in the second and third
   task automatic micro(input int sa, input int sb, input int sc, input logic we,
                        input logic [15:0] cv, input logic ml, input logic r,
                        input logic w, input logic drv, input logic [15:0] mv);
      sel_a = 5'(sa); sel_b = 5'(sb); sel_c = 5'(sc);
      c_we = we; c_bus = cv; mar_ld = ml; mem_rd = r; mem_wr = w;
      tb_drv = drv; tb_val = mv;
      @(negedge clk);
      ph_t2 = 1'b1;
      @(negedge clk);
      mid_a = a_bus; mid_addr = mem_addr; mid_mem = mem_data;
      ph_t2 = 1'b0; ph_t3 = 1'b1;
      @(negedge clk);
      ph_t3 = 1'b0; c_we = 1'b0; mar_ld = 1'b0; mem_rd = 1'b0;
      mem_wr = 1'b0; tb_drv = 1'b0;
   endtask

   task automatic peek(input int idx, output logic [15:0] a, output logic [15:0] b);
      sel_a = 5'(idx); sel_b = 5'(idx);
      #1;
      a = a_bus; b = b_bus;
   endtask

   function automatic logic [15:0] expect_reg(input int idx);
      case (idx)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'hFFFF;
         3: return 16'h8000;
         default: return (idx < 16) ? mdl[idx] : 16'h0000;
      endcase
   endfunction

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] ra, rb;
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(16'(mem_addr), 16'h0000, "R1 mem_addr after reset");
      for (int i = 4; i < 16; i++) begin
         peek(i, ra, rb);
         chk(ra, 16'h0000, $sformatf("R1 reg %0d after reset", i));
      end

      // R4 write with enable low has no effect
      micro(0, 0, 7, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
      peek(7, ra, rb);
      chk(ra, 16'h0000, "R4 c_we low leaves reg 7");

      // R2 R3 R4 sweep of all 32 write codes, then full readback
      for (int i = 0; i < 32; i++) begin
         logic [15:0] v;
         v = 16'(i * 16'h0973) ^ 16'h5A3C;
         micro(0, 0, i, 1'b1, v, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
         if (i >= 4 && i < 16) mdl[i] = v;
      end
      for (int i = 0; i < 32; i++) begin
         peek(i, ra, rb);
         chk(ra, expect_reg(i), $sformatf("R2 R3 R4 A read code %0d", i));
         chk(rb, expect_reg(i), $sformatf("R2 R3 B read code %0d", i));
      end

      // R5 address register loads from every register via B
      for (int i = 0; i < 16; i++) begin
         micro(0, i, 0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
         chk(16'(mem_addr), {4'h0, expect_reg(i)[11:0]}, $sformatf("R5 mar from reg %0d", i));
      end
      micro(0, 9, 0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
      chk(16'(mem_addr), {4'h0, expect_reg(15)[11:0]}, "R5 mar holds without load");

      // R6 increment of register 6 while copying it to the address register
      micro(0, 0, 6, 1'b1, 16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
      mdl[6] = 16'h0FFF;
      micro(6, 6, 6, 1'b1, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk(16'(mid_addr), 16'h0FFF, "R6 mar takes old value at t2");
      chk(mid_a, 16'h0FFF, "R6 A bus old before t3");
      chk(16'(mem_addr), 16'h0FFF, "R6 mar old after t3");
      peek(6, ra, rb);
      chk(ra, 16'h1000, "R6 register 6 updated");

      // R9 same register on A, B and C
      micro(9, 9, 9, 1'b1, ~mdl[9], 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
      chk(mid_a, mdl[9], "R9 A old before t3");
      mdl[9] = ~mdl[9];
      peek(9, ra, rb);
      chk(ra, mdl[9], "R9 A new after t3");
      chk(rb, mdl[9], "R9 B new after t3");

      // R7 memory read wins over a C write to the data register
      micro(0, 0, 5, 1'b1, 16'h1111, 1'b0, 1'b1, 1'b0, 1'b1, 16'h3C5A);
      peek(5, ra, rb);
      chk(ra, 16'h3C5A, "R7 memory read beats C write");

      // R8 write drives the data register onto the bus
      micro(0, 0, 5, 1'b1, 16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
      micro(0, 0, 0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
      chk(mid_mem, 16'hBEEF, "R8 write drives mem_data");
      // R8 after the write, the bus is released so an external value is captured
      micro(0, 0, 0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h7E81);
      chk(mid_mem, 16'h7E81, "R8 bus released on read");
      peek(5, ra, rb);
      chk(ra, 16'h7E81, "R8 R7 read value captured");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule